// File: doc/BRIEF.md
# Strap Capture and Pin Direction Controller

This block owns four dual-purpose pads that serve as configuration straps while power-on reset is held and as clock outputs once reset has ended. While reset is low the pad drivers stay off, and each pad level passes through a two-flop synchronizer. At the first clock edge after reset releases, the synchronized levels are loaded into a four-bit configuration register. The block raises a one-cycle strobe to mark the new configuration. One cycle after that it turns the pad drivers on, so the pads carry the clocks supplied on `clk_src`.

Downstream logic reads the held configuration as a bus-mode bit and a three-bit frequency code. The bus-mode bit is 1 for bus clocks running synchronously at half the processor clock, and 0 for a fixed asynchronous bus clock. One frequency code selects production test mode, and the block flags it. The configuration does not change until reset is asserted again. Reset is active low and asynchronous. Asserting it turns the drivers off at once and returns the register to the all-ones pattern that the internal pull-ups give on unstrapped pads.

A state machine drives the sequence. It has three states. ST_SAMPLE is entered by reset. It holds the drivers off and enables capture. ST_LATCH lasts one cycle. It raises the strobe and keeps the drivers off. ST_DRIVE enables the drivers. The named transitions are:
- T_RELEASE: ST_SAMPLE to ST_LATCH, at the first edge with reset high, where the capture happens.
- T_ENABLE: ST_LATCH to ST_DRIVE.
- T_HOLD: ST_DRIVE to itself.
- T_RESET: asynchronous, from any state to ST_SAMPLE.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `por_n` is 0, and during the strobe cycle, `pad_oe` is 0000 and `pad_o` is 0000.
- R2: After release, `bus_sync_sel` equals the level of pad 0, and `freq_sel[2:0]` equals the levels of pads 3..1 (pad 1 goes to bit 0). A level counts if it was held for at least three cycles before `por_n` rose.
- R3: `cfg_valid` is 1 for exactly one cycle, the cycle after the first rising clock edge with `por_n` high.
- R4: `pad_oe` goes to 1111 one cycle after the strobe. From then on `pad_o` follows `clk_src`.
- R5: After capture, `bus_sync_sel` and `freq_sel` stay constant whatever the pads do, until reset is asserted again.
- R6: `test_mode` is 1 exactly when a configuration has been captured and `freq_sel` is 3'b011 (bit0=1, bit1=1, bit2=0). The value of `bus_sync_sel` does not affect it.
- R7: Asserting `por_n` low drives `pad_oe` to 0 without waiting for a clock edge. It also returns `bus_sync_sel` to 1, `freq_sel` to 3'b111 and `test_mode` to 0. New levels are captured at the next release.
- R8: If reset is asserted during the strobe cycle, the drivers are never enabled. The next release captures the pad levels present at that later time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_i | input | 4 | Pad input levels (strap values during reset) |
| clk_src | input | 4 | Clocks to drive onto the pads once enabled |
| pad_o | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |
| bus_sync_sel | output | 1 | Held bus mode: 1 synchronous half-rate, 0 fixed asynchronous |
| freq_sel | output | 3 | Held frequency code |
| test_mode | output | 1 | Production test code selected |
| cfg_valid | output | 1 | One-cycle strobe when the configuration becomes valid |

## Verification
Two events can fall into the same cycle: the strobe that publishes a fresh configuration, and a new reset assertion that should throw it away. The bench provokes this by pulling `por_n` low in the middle of the strobe cycle. It then checks that the drivers stay off, that the fields return to their defaults, and that the next release captures the pad levels changed in the meantime, not the abandoned ones. A second overlap is pad levels changing right after the release edge. The bench changes them on the next falling edge and requires the held fields to keep the earlier values.

// File: rtl/strap_pkg.sv
package strap_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_LATCH  = 2'd1,
        ST_DRIVE  = 2'd2
    } strap_state_e;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Per-pad synchronizer chain; no reset so it runs while reset is held.
    for (genvar p = 0; p < WIDTH; p++) begin : g_pad
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            chain <= {chain[STAGES-2:0], din[p]};
        end
        assign dout[p] = chain[STAGES-1];
    end
endmodule

// File: rtl/strap_fsm.sv
module strap_fsm
    import strap_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    output logic capture_en,
    output logic strobe,
    output logic drive_en,
    output logic configured
);
    strap_state_e state_q, state_d;

    // State register; T_RESET is asynchronous.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_SAMPLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = ST_LATCH;   // T_RELEASE
            ST_LATCH:  state_d = ST_DRIVE;   // T_ENABLE
            ST_DRIVE:  state_d = ST_DRIVE;   // T_HOLD
            default:   state_d = ST_SAMPLE;
        endcase
    end

    always_comb begin
        capture_en = 1'b0;
        strobe     = 1'b0;
        drive_en   = 1'b0;
        configured = 1'b0;
        unique case (state_q)
            ST_SAMPLE: capture_en = 1'b1;
            ST_LATCH: begin
                strobe     = 1'b1;
                configured = 1'b1;
            end
            ST_DRIVE: begin
                drive_en   = 1'b1;
                configured = 1'b1;
            end
            default: capture_en = 1'b0;
        endcase
    end

    AST_DRIVE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!por_n)
        $rose(drive_en) |-> $past(strobe)) else $error("drive without strobe"); // R4
endmodule

// File: rtl/strap_cfg.sv
module strap_cfg #(
    parameter int          WIDTH     = 4,
    parameter logic [WIDTH-2:0] TEST_CODE = 3'b011
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             capture_en,
    input  logic             configured,
    input  logic [WIDTH-1:0] strap_d,
    output logic             bus_sync_sel,
    output logic [WIDTH-2:0] freq_sel,
    output logic             test_mode
);
    localparam int FS_W = WIDTH - 1;

    logic [WIDTH-1:0] cfg_q;

    // Unstrapped pads read high, so the default is all ones.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          cfg_q <= '1;
        else if (capture_en) cfg_q <= strap_d;
    end

    assign bus_sync_sel = cfg_q[0];
    assign freq_sel     = cfg_q[FS_W:1];
    assign test_mode    = configured && (cfg_q[FS_W:1] == TEST_CODE);

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (configured && $past(configured)) |-> $stable(cfg_q)) else $error("cfg changed"); // R5
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl #(
    parameter int NUM_STRAPS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic [NUM_STRAPS-1:0] pad_i,
    input  logic [NUM_STRAPS-1:0] clk_src,
    output logic [NUM_STRAPS-1:0] pad_o,
    output logic [NUM_STRAPS-1:0] pad_oe,
    output logic                  bus_sync_sel,
    output logic [NUM_STRAPS-2:0] freq_sel,
    output logic                  test_mode,
    output logic                  cfg_valid
);
    localparam int FS_W = NUM_STRAPS - 1;

    logic [NUM_STRAPS-1:0] strap_s;
    logic capture_en, drive_en, configured;

    strap_sync #(.WIDTH(NUM_STRAPS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pad_i),
        .dout (strap_s)
    );

    strap_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .capture_en (capture_en),
        .strobe     (cfg_valid),
        .drive_en   (drive_en),
        .configured (configured)
    );

    strap_cfg #(.WIDTH(NUM_STRAPS), .TEST_CODE(FS_W'(3))) u_cfg (
        .clk          (clk),
        .por_n        (por_n),
        .capture_en   (capture_en),
        .configured   (configured),
        .strap_d      (strap_s),
        .bus_sync_sel (bus_sync_sel),
        .freq_sel     (freq_sel),
        .test_mode    (test_mode)
    );

    assign pad_oe = {NUM_STRAPS{drive_en}};
    assign pad_o  = clk_src & pad_oe;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        cfg_valid |=> !cfg_valid) else $error("strobe too long"); // R3
    AST_NO_DRIVE_ON_STROBE: assert property (@(posedge clk) disable iff (!por_n)
        cfg_valid |-> (pad_oe == '0)) else $error("drive during strobe"); // R1
    AST_OE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pad_oe[0]) |-> $past(cfg_valid)) else $error("early drive"); // R4
    AST_TEST_ONLY_CONFIGURED: assert property (@(posedge clk) disable iff (!por_n)
        test_mode |-> (cfg_valid || pad_oe[0])) else $error("test before capture"); // R6
endmodule

// File: tb/strap_latch_ctrl_bench.sv
`timescale 1ns/1ps
module strap_latch_ctrl_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [3:0] pad_i = 4'b1111;
    logic [3:0] clk_src = 4'b0000;
    logic [3:0] pad_o, pad_oe;
    logic       bus_sync_sel, test_mode, cfg_valid;
    logic [2:0] freq_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    strap_latch_ctrl u_strap_latch_ctrl (
        .clk(clk), .por_n(por_n), .pad_i(pad_i), .clk_src(clk_src),
        .pad_o(pad_o), .pad_oe(pad_oe), .bus_sync_sel(bus_sync_sel),
        .freq_sel(freq_sel), .test_mode(test_mode), .cfg_valid(cfg_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_reset(input logic [3:0] straps);
        @(negedge clk);
        por_n = 1'b0;
        pad_i = straps;
        repeat (4) @(negedge clk);
    endtask

    // Release, then check the strobe cycle and the drive cycle.
    task automatic t_capture(input logic [3:0] straps);
        logic exp_test;
        exp_test = (straps[3:1] == 3'b011);
        hold_reset(straps);
        check("R1 oe in reset", 32'(pad_oe), 32'h0);
        check("R1 pad_o in reset", 32'(pad_o), 32'h0);
        por_n = 1'b1;
        @(negedge clk);
        pad_i = ~straps;  // change right after the release edge
        check("R3 strobe", 32'(cfg_valid), 32'h1);
        check("R1 oe during strobe", 32'(pad_oe), 32'h0);
        check("R2 bus sel", 32'(bus_sync_sel), 32'(straps[0]));
        check("R2 freq sel", 32'(freq_sel), 32'(straps[3:1]));
        check("R6 test mode", 32'(test_mode), 32'(exp_test));
        @(negedge clk);
        check("R3 strobe dropped", 32'(cfg_valid), 32'h0);
        check("R4 oe on", 32'(pad_oe), 32'hF);
        clk_src = 4'b1010;
        #1 check("R4 pad_o follows", 32'(pad_o), 32'hA);
        clk_src = 4'b0101;
        #1 check("R4 pad_o follows", 32'(pad_o), 32'h5);
    endtask

    task automatic t_hold(input logic [3:0] straps);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pad_i = 4'(i * 5 + 3);
        end
        repeat (3) @(negedge clk);
        check("R5 bus held", 32'(bus_sync_sel), 32'(straps[0]));
        check("R5 freq held", 32'(freq_sel), 32'(straps[3:1]));
        check("R5 still driving", 32'(pad_oe), 32'hF);
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        #2 por_n = 1'b0;
        #1;
        check("R7 oe off at once", 32'(pad_oe), 32'h0);
        check("R7 bus default", 32'(bus_sync_sel), 32'h1);
        check("R7 freq default", 32'(freq_sel), 32'h7);
        check("R7 test cleared", 32'(test_mode), 32'h0);
    endtask

    task automatic t_abort_strobe();
        hold_reset(4'b0110);
        por_n = 1'b1;
        @(negedge clk);
        check("R8 strobe seen", 32'(cfg_valid), 32'h1);
        por_n = 1'b0;
        pad_i = 4'b1000;
        #1 check("R8 strobe cancelled", 32'(cfg_valid), 32'h0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 no drive after abort", 32'(pad_oe), 32'h0);
        end
        por_n = 1'b1;
        @(negedge clk);
        check("R8 new freq", 32'(freq_sel), 32'h4);
        check("R8 new bus", 32'(bus_sync_sel), 32'h0);
        check("R8 test off", 32'(test_mode), 32'h0);
        @(negedge clk);
        check("R8 drive on", 32'(pad_oe), 32'hF);
    endtask

    initial begin
        clk_src = 4'b1111;
        repeat (2) @(negedge clk);
        check("R1 reset oe", 32'(pad_oe), 32'h0);
        check("R1 reset pad_o", 32'(pad_o), 32'h0);
        check("R3 reset strobe", 32'(cfg_valid), 32'h0);
        check("R6 reset test", 32'(test_mode), 32'h0);
        t_capture(4'b1111); t_hold(4'b1111);
        t_capture(4'b0000); t_hold(4'b0000);
        t_capture(4'b0110); t_hold(4'b0110);
        t_capture(4'b0111); t_hold(4'b0111);
        t_capture(4'b1001); t_hold(4'b1001);
        t_async_reset();
        t_capture(4'b1100);
        t_abort_strobe();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule